// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Accumulate

This unit takes two 32-bit source words and treats each as a pair of signed 16-bit halves. It multiplies the low halves together and the high halves together, then either adds or subtracts the two products. Before multiplying it can exchange the two halves of the second source, so the same datapath forms either the matched products (real times real, imaginary times imaginary) or the cross products. When the inputs are Q15 values the combined result is Q30. Later doubling and saturation are left to a following stage.

The combined value can be returned on its own, added to a 32-bit accumulator word, or sign-extended and added to a 64-bit accumulator. Operations flow through a two-stage pipeline that accepts one operation per cycle. A valid bit travels with the data. A sticky flag records any 32-bit result whose true value did not fit in a signed 32-bit word. The half width is a parameter, and every other width is derived from it.

Top module: `dual_mac16`

## Requirements
- R1: While reset is high, and in the cycle after the reset edge, `vld_o`, `ovf_o` and `res_o` are all zero.
- R2: An operation presented with `vld_i` high at a clock edge produces `vld_o` high two edges later. A cycle with `vld_i` low produces `vld_o` low two edges later. One new operation can be accepted on every cycle.
- R3: With `sub_i`=0 and `swap_i`=0, the combined value is signed(A[15:0])·signed(B[15:0]) + signed(A[31:16])·signed(B[31:16]).
- R4: With `sub_i`=1, the combined value is the low-half product minus the high-half product.
- R5: With `swap_i`=1, B[15:0] and B[31:16] are exchanged before multiplying. The products are then A-low·B-high and A-high·B-low.
- R6: Short mode (`long_i`=0) gives a 32-bit result. It is the combined value, plus signed `acc_i[31:0]` when `acc_en_i`=1, taken modulo 2^32. It appears in `res_o[31:0]`, and `res_o[63:32]` is zero.
- R7: Long mode (`long_i`=1) sign-extends the combined value to 64 bits. It adds all 64 bits of `acc_i` when `acc_en_i`=1, and returns the sum modulo 2^64 on `res_o`.
- R8: `ovf_o` goes high in the same cycle that `vld_o` delivers a short-mode result whose exact value lies outside [-2^31, 2^31-1]. This applies with or without accumulation. The flag then stays high until reset.
- R9: Long-mode operations never set `ovf_o`.
- R10: While `vld_o` is low, `res_o` holds the last delivered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Operation valid |
| src_a_i | input | 32 | First source, two signed halves |
| src_b_i | input | 32 | Second source, two signed halves |
| acc_i | input | 64 | Accumulator; short mode uses bits 31:0 |
| swap_i | input | 1 | Exchange halves of second source |
| sub_i | input | 1 | 1: low product minus high product; 0: sum |
| acc_en_i | input | 1 | Add accumulator |
| long_i | input | 1 | 1: 64-bit result; 0: 32-bit result |
| vld_o | output | 1 | Result valid |
| res_o | output | 64 | Result |
| ovf_o | output | 1 | Sticky short-mode overflow flag |

## Verification
Every result, its valid bit and any overflow update are due at the second rising edge after the operation is presented. The bench drives each operation on a falling edge and keeps a two-deep history of what it drove. On each later falling edge it compares the outputs with the entry driven two falling edges earlier. A reduced half width of 4 bits allows a full sweep of every operand pair while the control modes and valid gaps rotate. A directed run before the sweep covers overflow from a clean flag, and the final reset confirms that the flag clears.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic {
        COMB_ADD = 1'b0,
        COMB_SUB = 1'b1
    } comb_op_e;

    typedef struct packed {
        logic     swap;
        comb_op_e op;
        logic     acc_en;
        logic     long_m;
    } dmac_ctl_t;

    localparam dmac_ctl_t CTL_IDLE = '{swap: 1'b0, op: COMB_ADD, acc_en: 1'b0, long_m: 1'b0};

    function automatic dmac_ctl_t pack_ctl(input logic swap, input logic sub,
                                           input logic acc_en, input logic long_m);
        dmac_ctl_t c;
        c.swap   = swap;
        c.op     = sub ? COMB_SUB : COMB_ADD;
        c.acc_en = acc_en;
        c.long_m = long_m;
        return c;
    endfunction

endpackage

// File: rtl/dmac_mul_stage.sv
module dmac_mul_stage
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vld_i,
    input  logic [2*HALF_W-1:0]   a_i,
    input  logic [2*HALF_W-1:0]   b_i,
    input  logic [4*HALF_W-1:0]   acc_i,
    input  dmac_ctl_t             ctl_i,
    output logic                  vld_o,
    output logic [1:0][2*HALF_W-1:0] prod_o,
    output logic [4*HALF_W-1:0]   acc_o,
    output dmac_ctl_t             ctl_o
);
    localparam int P_W = 2 * HALF_W;
    localparam int A_W = 4 * HALF_W;

    logic [1:0][P_W-1:0] prod_d;

    // lane 0 multiplies the low halves, lane 1 the high halves
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [HALF_W-1:0]        a_half;
        logic [HALF_W-1:0]        b_half;
        logic signed [P_W-1:0]    p;
        assign a_half = a_i[g*HALF_W +: HALF_W];
        assign b_half = ctl_i.swap ? b_i[(1-g)*HALF_W +: HALF_W]
                                   : b_i[g*HALF_W +: HALF_W];
        assign p         = $signed(a_half) * $signed(b_half);
        assign prod_d[g] = p;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            prod_o <= '0;
            acc_o  <= '0;
            ctl_o  <= CTL_IDLE;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                prod_o <= prod_d;
                acc_o  <= acc_i;
                ctl_o  <= ctl_i;
            end
        end
    end

    logic unused_w;
    assign unused_w = ^A_W;

endmodule

// File: rtl/dmac_acc_stage.sv
module dmac_acc_stage
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_i,
    input  logic [1:0][2*HALF_W-1:0] prod_i,
    input  logic [4*HALF_W-1:0]      acc_i,
    input  dmac_ctl_t                ctl_i,
    output logic                     vld_o,
    output logic [4*HALF_W-1:0]      res_o,
    output logic                     ovf_o
);
    localparam int W   = 2 * HALF_W;
    localparam int L_W = 2 * W;

    logic [W:0]     ext_lo, ext_hi, comb;
    logic [W+1:0]   short_sum, short_acc;
    logic [L_W-1:0] long_sum, long_acc;
    logic           short_ovf;
    logic [L_W-1:0] res_d;

    assign ext_lo = {prod_i[0][W-1], prod_i[0]};
    assign ext_hi = {prod_i[1][W-1], prod_i[1]};
    assign comb   = (ctl_i.op == COMB_SUB) ? ext_lo - ext_hi : ext_lo + ext_hi;

    assign short_acc = ctl_i.acc_en ? {{2{acc_i[W-1]}}, acc_i[W-1:0]} : '0;
    assign short_sum = {comb[W], comb} + short_acc;
    // exact value fits when the top three bits agree
    assign short_ovf = !((short_sum[W+1:W-1] == 3'b000) || (short_sum[W+1:W-1] == 3'b111));

    assign long_acc = ctl_i.acc_en ? acc_i : '0;
    assign long_sum = {{(L_W-W-1){comb[W]}}, comb} + long_acc;

    assign res_d = ctl_i.long_m ? long_sum : {{W{1'b0}}, short_sum[W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            res_o <= '0;
            ovf_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                res_o <= res_d;
                if (!ctl_i.long_m && short_ovf) ovf_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_mac16.sv
module dual_mac16
    import dmac_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vld_i,
    input  logic [2*HALF_W-1:0]   src_a_i,
    input  logic [2*HALF_W-1:0]   src_b_i,
    input  logic [4*HALF_W-1:0]   acc_i,
    input  logic                  swap_i,
    input  logic                  sub_i,
    input  logic                  acc_en_i,
    input  logic                  long_i,
    output logic                  vld_o,
    output logic [4*HALF_W-1:0]   res_o,
    output logic                  ovf_o
);
    localparam int W = 2 * HALF_W;

    dmac_ctl_t           ctl_in, ctl_s1;
    logic                vld_s1;
    logic [1:0][W-1:0]   prod_s1;
    logic [2*W-1:0]      acc_s1;

    assign ctl_in = pack_ctl(swap_i, sub_i, acc_en_i, long_i);

    dmac_mul_stage #(.HALF_W(HALF_W)) i_mul (
        .clk(clk), .rst(rst), .vld_i(vld_i),
        .a_i(src_a_i), .b_i(src_b_i), .acc_i(acc_i), .ctl_i(ctl_in),
        .vld_o(vld_s1), .prod_o(prod_s1), .acc_o(acc_s1), .ctl_o(ctl_s1)
    );

    dmac_acc_stage #(.HALF_W(HALF_W)) i_acc (
        .clk(clk), .rst(rst), .vld_i(vld_s1),
        .prod_i(prod_s1), .acc_i(acc_s1), .ctl_i(ctl_s1),
        .vld_o(vld_o), .res_o(res_o), .ovf_o(ovf_o)
    );

endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                vld_i,
    input logic                long_i,
    input logic                vld_o,
    input logic [4*HALF_W-1:0] res_o,
    input logic                ovf_o
);
    localparam int W = 2 * HALF_W;

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> ##1 vld_o);

    // R2
    valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> ##1 !vld_o);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    // R8
    ovf_with_result_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> vld_o);

    // R9
    long_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> !$past(long_i, 2));

    // R6
    short_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !$past(long_i, 2)) |-> (res_o[2*W-1:W] == '0));

    // R10
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> $stable(res_o));

endmodule

bind dual_mac16 dmac_chk #(.HALF_W(HALF_W)) i_chk (
    .clk(clk), .rst(rst), .vld_i(vld_i), .long_i(long_i),
    .vld_o(vld_o), .res_o(res_o), .ovf_o(ovf_o)
);

// File: tb/test_dual_mac16.sv
module test_dual_mac16;
    localparam int CLK_P = 10;
    localparam int H = 4;
    localparam int W = 2 * H;
    localparam int L = 2 * W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         vld_i = 1'b0;
    logic [W-1:0] src_a_i = '0, src_b_i = '0;
    logic [L-1:0] acc_i = '0;
    logic         swap_i = 1'b0, sub_i = 1'b0, acc_en_i = 1'b0, long_i = 1'b0;
    logic         vld_o, ovf_o;
    logic [L-1:0] res_o;

    dual_mac16 #(.HALF_W(H)) i_dual_mac16 (
        .clk(clk), .rst(rst), .vld_i(vld_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .acc_i(acc_i), .swap_i(swap_i), .sub_i(sub_i), .acc_en_i(acc_en_i),
        .long_i(long_i), .vld_o(vld_o), .res_o(res_o), .ovf_o(ovf_o)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        bit v; logic [W-1:0] a, b; logic [L-1:0] acc; bit sw, sb, ae, lg;
    } op_t;

    op_t h0, h1;
    logic [L-1:0] exp_res;
    bit exp_ovf;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void model(input op_t o, output logic [L-1:0] r, output bit ov);
        logic [W-1:0] bb;
        longint alo, ahi, blo, bhi, c, t;
        bb  = o.sw ? {o.b[H-1:0], o.b[W-1:H]} : o.b;
        alo = longint'($signed(o.a[H-1:0]));
        ahi = longint'($signed(o.a[W-1:H]));
        blo = longint'($signed(bb[H-1:0]));
        bhi = longint'($signed(bb[W-1:H]));
        c   = o.sb ? alo*blo - ahi*bhi : alo*blo + ahi*bhi;
        ov  = 0;
        if (o.lg) begin
            t = c + (o.ae ? longint'($signed(o.acc)) : 0);
            r = t[L-1:0];
        end else begin
            t = c + (o.ae ? longint'($signed(o.acc[W-1:0])) : 0);
            ov = (t > (2**(W-1) - 1)) || (t < -(2**(W-1)));
            r = {{W{1'b0}}, t[W-1:0]};
        end
    endfunction

    task automatic check_cycle();
        logic [L-1:0] r; bit ov; string tag;
        if (h1.v) begin
            model(h1, r, ov);
            exp_res = r;
            if (ov) exp_ovf = 1;
            if (h1.lg) tag = "R7";
            else if (h1.ae) tag = "R6";
            else if (h1.sw) tag = "R5";
            else if (h1.sb) tag = "R4";
            else tag = "R3";
        end else tag = "R10";
        chk("R2 valid", L'(vld_o), L'(h1.v));
        chk(tag, res_o, exp_res);
        chk(h1.v && h1.lg ? "R9 ovf" : "R8 ovf", L'(ovf_o), L'(exp_ovf));
    endtask

    task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [L-1:0] acc, input bit sw, input bit sb,
                        input bit ae, input bit lg);
        @(negedge clk);
        check_cycle();
        h1 = h0;
        h0 = '{v, a, b, acc, sw, sb, ae, lg};
        vld_i = v; src_a_i = a; src_b_i = b; acc_i = acc;
        swap_i = sw; sub_i = sb; acc_en_i = ae; long_i = lg;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vld_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 vld", L'(vld_o), '0);
        chk("R1 res", res_o, '0);
        chk("R1 ovf", L'(ovf_o), '0);
        rst = 1'b0;
        h0 = '{0, '0, '0, '0, 0, 0, 0, 0};
        h1 = h0;
        exp_res = '0; exp_ovf = 0;
    endtask

    initial begin
        do_reset();
        // R9: long mode value that would overflow a short result
        step(1, 8'h88, 8'h88, '0, 0, 0, 0, 1);
        // R3 / R4 / R5 basic patterns
        step(1, 8'h21, 8'h13, '0, 0, 0, 0, 0);
        step(1, 8'h21, 8'h13, '0, 0, 1, 0, 0);
        step(1, 8'h21, 8'h13, '0, 1, 0, 0, 0);
        // R10 gap
        step(0, 8'hFF, 8'hFF, '1, 1, 1, 1, 1);
        // R6 short accumulate, no overflow
        step(1, 8'h7F, 8'h7F, 16'h0010, 0, 0, 1, 0);
        // R7 long accumulate with negative accumulator
        step(1, 8'h7F, 8'h81, 16'hF000, 1, 1, 1, 1);
        // R8 overflow without accumulate, then sticky
        step(1, 8'h88, 8'h88, '0, 0, 0, 0, 0);
        step(1, 8'h11, 8'h11, '0, 0, 0, 0, 0);
        step(0, '0, '0, '0, 0, 0, 0, 0);
        // full operand sweep with rotating modes and gaps
        for (int k = 0; k < 65536; k++) begin
            logic [15:0] kk; logic [3:0] m; logic [31:0] av;
            kk = 16'(k);
            m  = kk[3:0] ^ kk[11:8] ^ kk[15:12];
            av = 32'(k) * 32'd40503;
            step((k % 11) != 7, kk[7:0], kk[15:8], av[L-1:0], m[0], m[1], m[2], m[3]);
        end
        step(0, '0, '0, '0, 0, 0, 0, 0);
        step(0, '0, '0, '0, 0, 0, 0, 0);
        step(0, '0, '0, '0, 0, 0, 0, 0);
        // R1 reset clears sticky flag
        do_reset();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule